// File: doc/BRIEF.md
# Matrix Weight Crossbar Scheduler

This block decides, once per cell slot, which input of an N×N input-queued switch with virtual output queues may send to which output. A pulse on `start` loads a flattened matrix of per-queue weights, where entry (i, j) holds the backlog weight of input i's queue for output j. The block then runs a sequence of rounds, one clock cycle each. In every round it scores each live nonzero entry by how crowded its row and column are, grants the heaviest entries that do not share a row or column, and retires the granted rows and columns.

When nothing live remains, `done` pulses for one cycle. The per-input grants, each a valid bit plus an output index, stay on the outputs until the next accepted `start`. Ties between conflicting entries of equal score are broken by a free-running 16-bit LFSR. The LFSR rotates the row and column from which the winner search begins.

A binary mode treats every nonzero weight as 1, so the match favours grant count over backlog.

Top module: `xbar_sched`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and every bit of `grant_valid` are 0.
- R2: A `start` seen while `busy` is 0 loads the matrix, clears all grants and sets `busy` at that edge. A `start` seen while `busy` is 1 has no effect on the schedule under way or on its result.
- R3: The score of live entry (i, j) with value x > 0 is x/r + x/c. Here r and c count the live nonzero entries of row i and column j; entries of value 0 never win. In each round, an entry whose score is strictly larger than every other live score is granted.
- R4: Every live entry whose score equals the round maximum is granted in that same round, provided no two of them share a row or a column.
- R5: When maximum-score entries conflict, each row and each column receives at most one grant in the round. The winner is chosen through a pseudo-random rotation of the search start.
- R6: After a round, every row and column holding a winner is removed, and counts and scores are recomputed over the remaining live entries. The number of rounds is therefore the number of distinct maximum layers, at most N.
- R7: `done` is high for exactly one cycle, at the edge ending the round that leaves no live nonzero entry; `busy` falls at the same edge. An all-zero matrix completes after one round with no grant.
- R8: Each input holds at most one grant, and no output is named by two valid grants.
- R9: With `binary_mode` = 1 at the loading edge, every nonzero weight is treated as 1.
- R10: The grant of input i is `grant_valid[i]` together with `grant_idx[i*IW +: IW]` (IW = log2 N), which holds the output number. Grants hold their value while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load matrix and begin a schedule (ignored while busy) |
| binary_mode | input | 1 | Treat nonzero weights as 1 for this schedule |
| weights | input | N*N*WW | Entry (i,j) at bits [(i*N+j)*WW +: WW] |
| busy | output | 1 | A schedule is in progress |
| done | output | 1 | One-cycle pulse when the schedule completes |
| grant_valid | output | N | Input i holds a grant |
| grant_idx | output | N*IW | Output number granted to input i at [i*IW +: IW] |

## Verification
The matrix is captured at the edge that samples `start`. Each round then needs exactly one further edge, so `done` and the final grants appear right after edge k when k rounds are required. The bench raises `start` just after a falling edge, then counts rising edges and samples `done` at each falling edge. This count gives the round number, which is compared with the value worked out from the scores (1, 2 or 4 in the chosen matrices). Grants are read at the falling edge after `done`, and again several cycles later to confirm they are held.

// File: rtl/xsched_pkg.sv
package xsched_pkg;
  function automatic int clog2_min1(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/xsched_lfsr.sv
module xsched_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] q
);
  logic fb;
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[14:0], fb};
  end

  // LFSR must never reach the all-zero lock-up state (R5 tie source)
  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (rst) q != 16'h0);
endmodule

// File: rtl/xsched_weigh.sv
module xsched_weigh #(
  parameter int N  = 4,
  parameter int WW = 4,
  parameter int CW = 3,
  parameter int NW = WW + CW + 1,
  parameter int DW = 2 * CW
) (
  input  logic [N*N*WW-1:0] x,
  input  logic [N-1:0]      row_live,
  input  logic [N-1:0]      col_live,
  output logic [N*N-1:0]    live,
  output logic [N*N*NW-1:0] num,
  output logic [N*N*DW-1:0] den
);
  logic [CW-1:0] rcnt [N];
  logic [CW-1:0] ccnt [N];

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_row
      for (gj = 0; gj < N; gj++) begin : g_col
        localparam int K = gi * N + gj;
        assign live[K] = (x[K*WW +: WW] != '0) && row_live[gi] && col_live[gj];
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rcnt[i] = '0;
      ccnt[i] = '0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rcnt[i] = rcnt[i] + CW'(live[i*N+j]);
        ccnt[j] = ccnt[j] + CW'(live[i*N+j]);
      end
  end

  // score x/r + x/c kept as fraction x*(r+c) / (r*c)
  generate
    for (gi = 0; gi < N; gi++) begin : g_srow
      for (gj = 0; gj < N; gj++) begin : g_scol
        localparam int K = gi * N + gj;
        logic [CW:0] rc_sum;
        assign rc_sum = {1'b0, rcnt[gi]} + {1'b0, ccnt[gj]};
        assign num[K*NW +: NW] = NW'(x[K*WW +: WW]) * NW'(rc_sum);
        assign den[K*DW +: DW] = DW'(rcnt[gi]) * DW'(ccnt[gj]);
      end
    end
  endgenerate
endmodule

// File: rtl/xsched_select.sv
module xsched_select #(
  parameter int N  = 4,
  parameter int NW = 8,
  parameter int DW = 6,
  parameter int PW = NW + DW
) (
  input  logic [N*N-1:0]    live,
  input  logic [N*N*NW-1:0] num,
  input  logic [N*N*DW-1:0] den,
  input  logic [15:0]       rnd,
  output logic [N*N-1:0]    win
);
  logic [NW-1:0]  best_num;
  logic [DW-1:0]  best_den;
  logic           have;
  logic [N*N-1:0] tie;
  logic [N-1:0]   rtaken, ctaken;
  int             rot_r, rot_c, ii, jj;

  // maximum score by cross-multiplied comparison
  always_comb begin
    best_num = '0;
    best_den = '0;
    have     = 1'b0;
    for (int k = 0; k < N*N; k++) begin
      if (live[k] && (!have ||
          (PW'(num[k*NW +: NW]) * PW'(best_den) > PW'(best_num) * PW'(den[k*DW +: DW])))) begin
        best_num = num[k*NW +: NW];
        best_den = den[k*DW +: DW];
        have     = 1'b1;
      end
    end
    for (int k = 0; k < N*N; k++)
      tie[k] = live[k] &&
               (PW'(num[k*NW +: NW]) * PW'(best_den) == PW'(best_num) * PW'(den[k*DW +: DW]));
  end

  // greedy non-conflicting pick among maxima, start rotated by rnd
  always_comb begin
    rot_r  = int'(rnd[7:0])  % N;
    rot_c  = int'(rnd[15:8]) % N;
    rtaken = '0;
    ctaken = '0;
    win    = '0;
    for (int rr = 0; rr < N; rr++) begin
      ii = (rot_r + rr) % N;
      for (int cc = 0; cc < N; cc++) begin
        jj = (rot_c + cc) % N;
        if (tie[ii*N+jj] && !rtaken[ii] && !ctaken[jj]) begin
          win[ii*N+jj] = 1'b1;
          rtaken[ii]   = 1'b1;
          ctaken[jj]   = 1'b1;
        end
      end
    end
  end

  // a live matrix always yields progress (R6), winners are a subset of live
  always_comb begin
    assert_progress_R6: assert (!(|live) || (|win));
    assert_win_live_R3: assert ((win & ~live) == '0);
  end
endmodule

// File: rtl/xbar_sched.sv
module xbar_sched #(
  parameter int N  = 4,
  parameter int WW = 4,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int IW = xsched_pkg::clog2_min1(N),
  localparam int CW = xsched_pkg::clog2_min1(N + 1),
  localparam int NW = WW + CW + 1,
  localparam int DW = 2 * CW,
  localparam int RW = xsched_pkg::clog2_min1(N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              binary_mode,
  input  logic [N*N*WW-1:0] weights,
  output logic              busy,
  output logic              done,
  output logic [N-1:0]      grant_valid,
  output logic [N*IW-1:0]   grant_idx
);
  logic [N*N*WW-1:0] x_q, x_load;
  logic [N-1:0]      row_live, col_live;
  logic [N*N-1:0]    live, win;
  logic [N*N*NW-1:0] num;
  logic [N*N*DW-1:0] den;
  logic [15:0]       rnd;
  logic [N-1:0]      row_kill, col_kill;
  logic              rem_any;
  logic [RW-1:0]     round_cnt;

  xsched_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .q(rnd));

  xsched_weigh #(.N(N), .WW(WW), .CW(CW), .NW(NW), .DW(DW)) u_weigh (
    .x(x_q), .row_live(row_live), .col_live(col_live),
    .live(live), .num(num), .den(den));

  xsched_select #(.N(N), .NW(NW), .DW(DW)) u_select (
    .live(live), .num(num), .den(den), .rnd(rnd), .win(win));

  genvar gk;
  generate
    for (gk = 0; gk < N*N; gk++) begin : g_load
      assign x_load[gk*WW +: WW] = binary_mode ?
        WW'(weights[gk*WW +: WW] != '0) : weights[gk*WW +: WW];
    end
  endgenerate

  always_comb begin
    row_kill = '0;
    col_kill = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (win[i*N+j]) begin
          row_kill[i] = 1'b1;
          col_kill[j] = 1'b1;
        end
    rem_any = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (live[i*N+j] && !row_kill[i] && !col_kill[j]) rem_any = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      grant_valid <= '0;
      grant_idx   <= '0;
      row_live    <= '0;
      col_live    <= '0;
      x_q         <= '0;
      round_cnt   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          x_q         <= x_load;
          row_live    <= '1;
          col_live    <= '1;
          grant_valid <= '0;
          grant_idx   <= '0;
          round_cnt   <= '0;
          busy        <= 1'b1;
        end
      end else begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (win[i*N+j]) begin
              grant_valid[i]         <= 1'b1;
              grant_idx[i*IW +: IW]  <= IW'(j);
            end
        row_live  <= row_live & ~row_kill;
        col_live  <= col_live & ~col_kill;
        round_cnt <= round_cnt + 1'b1;
        if (!rem_any) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  generate
    for (gk = 0; gk < N; gk++) begin : g_chk
      logic [N-1:0] users;
      always_comb
        for (int i = 0; i < N; i++)
          users[i] = grant_valid[i] && (grant_idx[i*IW +: IW] == IW'(gk));
      assert_output_unique_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(users));
    end
  endgenerate

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_round_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (round_cnt < RW'(N)));
  assert_matrix_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(x_q));
  assert_grants_held_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(grant_valid) && $stable(grant_idx)));
endmodule

// File: tb/xbar_sched_tb.sv
module xbar_sched_tb;
  localparam int N  = 4;
  localparam int WW = 4;
  localparam int IW = 2;
  localparam int NV = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              binary_mode = 1'b0;
  logic [N*N*WW-1:0] weights = '0;
  logic              busy, done;
  logic [N-1:0]      grant_valid;
  logic [N*IW-1:0]   grant_idx;

  int errors = 0;
  int checks = 0;
  int rounds;

  always #4 clk = ~clk;

  xbar_sched #(.N(N), .WW(WW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .binary_mode(binary_mode),
    .weights(weights), .busy(busy), .done(done),
    .grant_valid(grant_valid), .grant_idx(grant_idx));

  // entry (i,j) is hex digit i*4+j from the right
  localparam logic [63:0] V_W [NV] = '{
    64'h5000_0500_0050_0005,   // diagonal of equal weights
    64'h0000_0000_0000_0000,   // empty
    64'h0000_0000_0020_0013,   // unique max then leftover
    64'h0000_0000_0009_0019,   // weighted
    64'h0000_0000_0009_0019,   // same, binary mode
    64'h0000_0000_0000_1111,   // conflicting ties in one row
    64'h0004_0030_0200_1000    // anti-diagonal, distinct scores
  };
  localparam logic       V_BIN [NV] = '{0, 0, 0, 0, 1, 0, 0};
  localparam logic [3:0] V_VAL [NV] = '{4'hF, 4'h0, 4'h3, 4'h3, 4'h3, 4'h1, 4'hF};
  localparam logic [7:0] V_IDX [NV] = '{8'hE4, 8'h00, 8'h04, 8'h01, 8'h01, 8'h00, 8'h1B};
  localparam logic       V_ANY [NV] = '{0, 0, 0, 0, 0, 1, 0};
  localparam int         V_RND [NV] = '{1, 1, 2, 2, 1, 1, 4};
  localparam string      V_REQ [NV] = '{"R4", "R7", "R3/R6", "R3", "R9", "R5", "R6"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_distinct(input string req);
    logic ok;
    ok = 1'b1;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (grant_valid[a] && grant_valid[b] &&
            grant_idx[a*IW +: IW] == grant_idx[b*IW +: IW]) ok = 1'b0;
    check(req, {31'd0, ok}, 32'd1);
  endtask

  // start pulse, then count edges until done; extra_start re-pulses mid-run
  task automatic run(input logic [63:0] w, input logic bin, input int extra_at,
                     input logic [63:0] w2);
    @(negedge clk);
    weights = w; binary_mode = bin; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    rounds = 0;
    for (int t = 0; t < 40; t++) begin
      @(posedge clk);
      rounds++;
      @(negedge clk);
      if (rounds == extra_at) begin weights = w2; binary_mode = 1'b1; start = 1'b1; end
      else start = 1'b0;
      if (done) break;
    end
    start = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 grants", {28'd0, grant_valid}, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      run(V_W[v], V_BIN[v], 0, 64'h0);
      check({V_REQ[v], " R7 rounds"}, rounds, V_RND[v]);
      check({V_REQ[v], " valid"}, {28'd0, grant_valid}, {28'd0, V_VAL[v]});
      if (V_ANY[v]) check_distinct({V_REQ[v], " R8 distinct"});
      else          check({V_REQ[v], " R10 idx"}, {24'd0, grant_idx}, {24'd0, V_IDX[v]});
      check("R7 busy low at done", {31'd0, busy}, 32'd0);
    end

    // R8 full tie matrix: a complete permutation in one round
    run(64'h7777_7777_7777_7777, 1'b0, 0, 64'h0);
    check("R4 full tie rounds", rounds, 1);
    check("R8 full tie valid", {28'd0, grant_valid}, 32'h0000_000F);
    check_distinct("R8 full tie distinct");

    // R7 done lasts one cycle
    @(negedge clk);
    check("R7 done pulse", {31'd0, done}, 32'd0);

    // R2 start while busy ignored: anti-diagonal run, second start at round 2
    run(64'h0004_0030_0200_1000, 1'b0, 2, 64'h1111_1111_1111_1111);
    check("R2 ignored rounds", rounds, 4);
    check("R2 ignored idx", {24'd0, grant_idx}, 32'h0000_001B);
    check("R2 ignored valid", {28'd0, grant_valid}, 32'h0000_000F);

    // R10 grants held while idle
    repeat (5) @(negedge clk);
    check("R10 held idx", {24'd0, grant_idx}, 32'h0000_001B);
    check("R10 held valid", {28'd0, grant_valid}, 32'h0000_000F);

    // R2 a new start clears old grants
    run(64'h0, 1'b0, 0, 64'h0);
    check("R2 cleared", {28'd0, grant_valid}, 32'd0);

    // R1 reset mid-run
    @(negedge clk);
    weights = 64'h0004_0030_0200_1000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    check("R1 reset grants", {28'd0, grant_valid}, 32'd0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule